// File: doc/BRIEF.md
# Sampled-Delay Glitch Suppression Filter

This block cleans a slow single-bit line, typically the clock wire of a synchronous serial link, by removing spikes and narrow pulses before the signal reaches the rest of the chip. It runs entirely on one 8 MHz reference clock. The raw line first passes through a two-flop synchronizer. It is then sampled twice in a row on a strobe picked from a divide-by-2 chain. The output moves to a new level only when both delayed samples hold that level. A disturbance shorter than one strobe period can be caught by at most one sample, so it never reaches the output. A genuine level lasts much longer than the strobe period, and it passes through after a short, bounded delay.

The strobe rate is chosen by a 2-bit select, which sets the width of pulse that is rejected. The free-running divider taps stay available as square waves and single-cycle strobes for neighbouring logic. When the select changes, the strobe phase counter starts over. The sample registers and the output keep their values, so changing the rate causes no output event.

Top module: `glitch_filter`

## Requirements
- R1: While `rst` is high at a clock edge, after that edge `sig_out`, every `div_tap` bit and every `strobe_tap` bit are 0, whatever `sig_in` does.
- R2: The divider count is 0 during reset and advances by one at each edge after reset. After the j-th edge with `rst` low (j = 1, 2, ...), `div_tap[k]` equals bit k of (j mod 16). `div_tap[0]` is therefore a 4 MHz square wave, `div_tap[1]` 2 MHz, `div_tap[2]` 1 MHz and `div_tap[3]` 500 kHz.
- R3: `strobe_tap[k]` is high for exactly one reference cycle, when the low k+1 bits of that same count are all ones. This gives one 125 ns pulse every 2^(k+1) cycles.
- R4: `rate_sel` sets the sampling period P in reference cycles: 0 gives P=2, 1 gives P=4, 2 gives P=8 and 3 gives P=16. Two sample strobes are never on consecutive cycles.
- R5: With `rate_sel` constant, a new level on `sig_in` that is first seen at edge t and then held for at least 2P+3 cycles appears on `sig_out` no earlier than edge t+P+3 and no later than edge t+2P+2.
- R6: A pulse of either polarity on `sig_in` that lasts fewer than P cycles never changes `sig_out`. `sig_out` only changes to a level that both delayed samples held at the edge before.
- R7: If `rate_sel` takes a new value and `sig_in` takes a new held level both first seen at edge t, the strobe phase restarts and `sig_out` changes at exactly edge t+2P+1, with P set by the new select value.
- R8: Changing `rate_sel` while `sig_in` is steady leaves `sig_out` unchanged, and no sample strobe occurs on the cycle in which the change is seen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 8 MHz reference clock |
| rst | input | 1 | Synchronous active-high reset |
| sig_in | input | 1 | Raw line to be filtered (asynchronous) |
| rate_sel | input | 2 | Sampling period select: 0=/2, 1=/4, 2=/8, 3=/16 |
| sig_out | output | 1 | Filtered line, low after reset |
| div_tap | output | 4 | Square-wave divider taps, bit k = reference / 2^(k+1) |
| strobe_tap | output | 4 | One-cycle pulse taps, bit k every 2^(k+1) cycles |

## Verification
Every output has its own timing, counted in clock edges. The divider taps are a pure function of the edges counted since reset release. A filtered level lands in the window from P+3 to 2P+2 edges after the input is first seen. After a combined select and level change, the output lands at exactly 2P+1 edges. The scoreboard stores each expected transition with its window bounds. The monitor samples on falling edges and checks the previous level one edge before the window opens and the new level at its closing edge. Glitch and select-only stimuli are followed by at least 2P+6 cycles in which the output must not move.

// File: rtl/glitch_pkg.sv
package glitch_pkg;

    localparam int unsigned DIV_STAGES = 4;
    localparam int unsigned CNT_W      = DIV_STAGES;
    localparam int unsigned SEL_W      = $clog2(DIV_STAGES);

    typedef enum logic [SEL_W-1:0] {
        RATE_DIV2  = 2'd0,
        RATE_DIV4  = 2'd1,
        RATE_DIV8  = 2'd2,
        RATE_DIV16 = 2'd3
    } rate_e;

    typedef struct packed {
        logic early;
        logic late;
    } sample_pair_t;

    // Last phase count value of a strobe period: 2^(sel+1) - 1.
    function automatic logic [CNT_W-1:0] strobe_limit(input rate_e sel);
        logic [CNT_W:0] span;
        span = (CNT_W+1)'(1) << (int'(sel) + 1);
        return CNT_W'(span - 1'b1);
    endfunction

endpackage

// File: rtl/gf_tap_chain.sv
module gf_tap_chain
    import glitch_pkg::*;
#(
    parameter int unsigned STAGES = DIV_STAGES
) (
    input  logic              clk,
    input  logic              rst,
    output logic [STAGES-1:0] div_tap,
    output logic [STAGES-1:0] strobe_tap
);

    logic [STAGES-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + STAGES'(1);
        end
    end

    assign div_tap = cnt_q;

    // Each stage pulses once per wrap of the bits below and including it.
    for (genvar k = 0; k < STAGES; k++) begin : g_strobe
        assign strobe_tap[k] = &cnt_q[k:0];
    end

endmodule

// File: rtl/gf_strobe_gen.sv
module gf_strobe_gen
    import glitch_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  rate_e sel,
    output logic  stb
);

    rate_e            sel_q;
    logic [CNT_W-1:0] phase_q;
    logic             sel_change;
    logic             at_limit;

    assign sel_change = (sel != sel_q);
    assign at_limit   = (phase_q == strobe_limit(sel_q));
    assign stb        = at_limit && !sel_change;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q   <= RATE_DIV2;
            phase_q <= '0;
        end else begin
            sel_q <= sel;
            if (sel_change || at_limit) begin
                phase_q <= '0;
            end else begin
                phase_q <= phase_q + CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/gf_sync.sv
module gf_sync #(
    parameter int unsigned DEPTH = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);

    logic [DEPTH-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[DEPTH-2:0], din};
        end
    end

    assign dout = chain_q[DEPTH-1];

endmodule

// File: rtl/gf_sample_pair.sv
module gf_sample_pair
    import glitch_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         stb,
    input  logic         din,
    output sample_pair_t samples,
    output logic         dout
);

    sample_pair_t smp_q;
    logic         out_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            smp_q <= '0;
        end else if (stb) begin
            smp_q.early <= din;
            smp_q.late  <= smp_q.early;
        end
    end

    // Output follows only when both delayed samples agree.
    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= 1'b0;
        end else if (smp_q.early == smp_q.late) begin
            out_q <= smp_q.early;
        end
    end

    assign samples = smp_q;
    assign dout    = out_q;

endmodule

// File: rtl/glitch_filter.sv
module glitch_filter
    import glitch_pkg::*;
#(
    parameter int unsigned SYNC_DEPTH = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  sig_in,
    input  logic [SEL_W-1:0]      rate_sel,
    output logic                  sig_out,
    output logic [DIV_STAGES-1:0] div_tap,
    output logic [DIV_STAGES-1:0] strobe_tap
);

    logic         line_sync;
    logic         sel_stb;
    sample_pair_t smp_q;

    gf_tap_chain #(.STAGES(DIV_STAGES)) u_taps (
        .clk        (clk),
        .rst        (rst),
        .div_tap    (div_tap),
        .strobe_tap (strobe_tap)
    );

    gf_strobe_gen u_stb (
        .clk (clk),
        .rst (rst),
        .sel (rate_e'(rate_sel)),
        .stb (sel_stb)
    );

    gf_sync #(.DEPTH(SYNC_DEPTH)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (sig_in),
        .dout (line_sync)
    );

    gf_sample_pair u_pair (
        .clk     (clk),
        .rst     (rst),
        .stb     (sel_stb),
        .din     (line_sync),
        .samples (smp_q),
        .dout    (sig_out)
    );

endmodule

// File: rtl/gf_checker.sv
module gf_checker
    import glitch_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic [SEL_W-1:0]      rate_sel,
    input logic                  sig_out,
    input logic [DIV_STAGES-1:0] div_tap,
    input logic [DIV_STAGES-1:0] strobe_tap,
    input logic                  stb,
    input logic                  smp_early,
    input logic                  smp_late
);

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (!sig_out && div_tap == '0 && strobe_tap == '0)); // R1

    AST_TAP0_TOGGLES: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (div_tap[0] != $past(div_tap[0]))); // R2

    AST_STROBE_ON_HIGH_TAP: assert property (@(posedge clk) disable iff (rst)
        (|strobe_tap) |-> div_tap[0]); // R3

    AST_STROBE_SPARSE: assert property (@(posedge clk) disable iff (rst)
        stb |=> !stb); // R4

    AST_OUT_FROM_AGREEMENT: assert property (@(posedge clk) disable iff (rst)
        (sig_out != $past(sig_out)) |->
            ($past(smp_early) == $past(smp_late) && $past(smp_late) == sig_out)); // R6

    AST_SEL_CHANGE_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
        (rate_sel != $past(rate_sel)) |-> !stb); // R8

endmodule

bind glitch_filter gf_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .rate_sel   (rate_sel),
    .sig_out    (sig_out),
    .div_tap    (div_tap),
    .strobe_tap (strobe_tap),
    .stb        (sel_stb),
    .smp_early  (smp_q.early),
    .smp_late   (smp_q.late)
);

// File: tb/tb_glitch_filter.sv
module tb_glitch_filter;

    localparam int CLK_PERIOD = 10;

    logic       clk      = 1'b0;
    logic       rst      = 1'b1;
    logic       sig_in   = 1'b0;
    logic [1:0] rate_sel = 2'd0;
    logic       sig_out;
    logic [3:0] div_tap;
    logic [3:0] strobe_tap;

    glitch_filter dut (
        .clk        (clk),
        .rst        (rst),
        .sig_in     (sig_in),
        .rate_sel   (rate_sel),
        .sig_out    (sig_out),
        .div_tap    (div_tap),
        .strobe_tap (strobe_tap)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int   n_tests = 0;
    int   n_fail  = 0;
    logic exp_level = 1'b0;

    typedef struct {
        logic  old_lvl;
        logic  new_lvl;
        int    lo;
        int    hi;
        string tag;
    } exp_t;
    exp_t sb_q[$];

    task automatic check(input bit ok, input string tag, input logic [3:0] act, input logic [3:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s at cycle %0d: actual=%0h expected=%0h", tag, cyc, act, exp);
        end
    endtask

    function automatic int period(input logic [1:0] s);
        return 2 << s;
    endfunction

    // Monitor: previous level one edge before the window opens, new level at its close.
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            if (cyc == sb_q[0].lo - 1)
                check(sig_out == sb_q[0].old_lvl, {sb_q[0].tag, " early"},
                      {3'b0, sig_out}, {3'b0, sb_q[0].old_lvl});
            if (cyc == sb_q[0].hi) begin
                check(sig_out == sb_q[0].new_lvl, {sb_q[0].tag, " arrive"},
                      {3'b0, sig_out}, {3'b0, sb_q[0].new_lvl});
                void'(sb_q.pop_front());
            end
        end
    end

    // R5: held level appears in [t+P+3, t+2P+2]
    task automatic drive_level(input logic lvl);
        int p;
        int t;
        @(negedge clk);
        p = period(rate_sel);
        t = cyc + 1;
        sb_q.push_back('{exp_level, lvl, t + p + 3, t + 2*p + 2, "R5"});
        sig_in    = lvl;
        exp_level = lvl;
        repeat (2*p + 6) @(negedge clk);
    endtask

    // R6: pulse shorter than P never reaches the output
    task automatic glitch(input int width);
        int p;
        bit bad;
        @(negedge clk);
        p   = period(rate_sel);
        bad = 1'b0;
        sig_in = ~exp_level;
        repeat (width) @(negedge clk);
        sig_in = exp_level;
        for (int i = 0; i < 2*p + 6; i++) begin
            if (sig_out != exp_level) bad = 1'b1;
            @(negedge clk);
        end
        check(!bad, "R6 glitch rejected", {3'b0, ~exp_level}, {3'b0, exp_level});
    endtask

    // R7: select and level change together, output lands at exactly t+2P+1
    task automatic restart_level(input logic [1:0] new_sel, input logic lvl);
        int p;
        int t;
        @(negedge clk);
        p = period(new_sel);
        t = cyc + 1;
        sb_q.push_back('{exp_level, lvl, t + 2*p + 1, t + 2*p + 1, "R7"});
        rate_sel  = new_sel;
        sig_in    = lvl;
        exp_level = lvl;
        repeat (2*p + 6) @(negedge clk);
    endtask

    // R8: select changes alone leave the output untouched
    task automatic sel_only();
        bit bad;
        bad = 1'b0;
        for (int s = 0; s < 8; s++) begin
            @(negedge clk);
            rate_sel = 2'(s * 3 + 1);
            for (int i = 0; i < 3; i++) begin
                if (sig_out != exp_level) bad = 1'b1;
                @(negedge clk);
            end
        end
        for (int i = 0; i < 40; i++) begin
            if (sig_out != exp_level) bad = 1'b1;
            @(negedge clk);
        end
        check(!bad, "R8 select change holds output", {3'b0, sig_out}, {3'b0, exp_level});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired at cycle %0d: actual=running expected=done", cyc);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int c_rel;
        // R1: reset state, input activity ignored
        repeat (2) @(negedge clk);
        sig_in = 1'b1;
        repeat (4) @(negedge clk);
        check(sig_out == 1'b0, "R1 out low in reset", {3'b0, sig_out}, 4'h0);
        check(div_tap == 4'h0, "R1 div_tap zero in reset", div_tap, 4'h0);
        check(strobe_tap == 4'h0, "R1 strobe_tap zero in reset", strobe_tap, 4'h0);
        sig_in = 1'b0;
        rst    = 1'b0;
        c_rel  = cyc;

        // R2 / R3: divider taps versus edges since release
        for (int i = 0; i < 40; i++) begin
            logic [3:0] n;
            logic [3:0] exp_stb;
            @(negedge clk);
            n = 4'((cyc - c_rel) % 16);
            for (int k = 0; k < 4; k++) exp_stb[k] = ((n & 4'((2 << k) - 1)) == 4'((2 << k) - 1));
            check(div_tap == n, "R2 div_tap", div_tap, n);
            check(strobe_tap == exp_stb, "R3 strobe_tap", strobe_tap, exp_stb);
        end

        // R4 / R5 / R6 at each rate
        for (int s = 0; s < 4; s++) begin
            @(negedge clk);
            rate_sel = 2'(s);
            repeat (3) @(negedge clk);
            drive_level(1'b1);
            glitch(period(2'(s)) - 1);
            drive_level(1'b0);
            glitch(period(2'(s)) - 1);
            glitch(1);
        end

        // R7: phase restart timing
        restart_level(2'd1, 1'b1);
        restart_level(2'd2, 1'b0);
        restart_level(2'd0, 1'b1);

        // R8 with output high, then low
        sel_only();
        @(negedge clk);
        rate_sel = 2'd1;
        repeat (3) @(negedge clk);
        drive_level(1'b0);
        sel_only();

        repeat (5) @(negedge clk);
        check(sb_q.size() == 0, "R5 scoreboard drained", 4'(sb_q.size()), 4'h0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule